// File: doc/BRIEF.md
# Integer Execute Unit with Status Flags

This block is the combinational integer datapath of a small 32-bit RISC core. Each cycle the core presents two operands, a 5-bit operation code and the architectural flag bits it currently holds: carry, overflow and the single compare flag used by conditional branches and moves. The unit returns a result word together with the next values of those three flags. When overflow trapping is enabled, it also raises a request for a range exception.

The operation set covers several groups:
- addition with and without carry-in, subtraction, multiply and divide in signed and unsigned forms;
- the bitwise logical operations, shifts and rotate;
- byte and halfword extension;
- a flag-driven select;
- one-based bit scans from either end;
- an upper-half immediate load;
- ten compares that set the compare flag.

Flags that an operation does not define pass through unchanged. The core can therefore write all three flag outputs back on every instruction. The register file, instruction decode and exception vectoring sit outside this unit.

Top module: `int_exec_alu`

## Requirements
- R1: ADD (code 0) and ADDC (code 1) return the low 32 bits of A+B, where ADDC also adds `carry_in`. Carry is the carry-out of the full sum. Overflow is set when A and B have the same sign and the result's sign differs from it.
- R2: SUB (code 2) returns A−B. Carry is set when A is unsigned-less-than B. Overflow is set when A and B differ in sign and the result's sign differs from A's.
- R3: MULS (code 3) returns the low word of the signed product and sets overflow when the upper word is not the sign extension of the low word. MULU (code 4) returns the low word of the unsigned product and sets carry when the upper word is nonzero. Each leaves its other flag unchanged.
- R4: DIVS (code 5) and DIVU (code 6) return the truncated quotient. With a zero divisor they return A unchanged, and DIVS sets overflow while DIVU sets carry. The flag is otherwise cleared. The other flag is left unchanged.
- R5: AND, OR and XOR are codes 7, 8 and 9. SLL, SRL, SRA and ROR (rotate right) are codes 10 to 13. Shift and rotate amounts use only B[4:0].
- R6: The extensions each take the low part of A: sign-extended byte (code 14), zero-extended byte (15), sign-extended halfword (16) and zero-extended halfword (17).
- R7: FF1 (code 19) returns the 1-based index of the lowest set bit of A. FL1 (code 20) returns the 1-based index of the highest set bit of A. Both return 0 when A is 0.
- R8: MOVHI (code 21) returns B[15:0] in bits 31:16, with zeros below.
- R9: CMOV (code 18) returns A when `flag_in` is 1 and B otherwise.
- R10: Codes 22 to 31 write the compare flag. The order is eq, ne, then unsigned gt/ge/lt/le, then signed gt/ge/lt/le. The result is 0. Every other code passes `flag_in` through.
- R11: Codes 7 to 31 pass `carry_in` and `ovf_in` through unchanged.
- R12: `range_exc` is 1 only when `trap_en` is 1 and the operation has just set a flag it defines. For codes 0 to 2 that flag is carry or overflow. For MULS and DIVS it is overflow. For MULU and DIVU it is carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, shift amount or immediate |
| opcode | input | 5 | Operation select |
| carry_in | input | 1 | Current carry flag |
| ovf_in | input | 1 | Current overflow flag |
| flag_in | input | 1 | Current compare flag |
| trap_en | input | 1 | Overflow-trap enable |
| result | output | 32 | Operation result |
| carry_out | output | 1 | Next carry flag |
| ovf_out | output | 1 | Next overflow flag |
| flag_out | output | 1 | Next compare flag |
| range_exc | output | 1 | Range-exception request |

## Verification
The unit holds no state, so any fault shows at the ports in the same cycle the operands are applied. A wrong flag rule shows as a carry, overflow or compare bit that differs from an independent 64-bit model for that opcode. A pass-through path that leaks shows as a flag that changes under a logical or compare operation. Corner operands are swept across all 32 codes because the sign boundary, all-ones and a zero divisor expose most faults in carry, sign or bit-scan logic.

// File: rtl/int_exec_alu.sv
module int_exec_alu #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [4:0]       opcode,
  input  logic             carry_in,
  input  logic             ovf_in,
  input  logic             flag_in,
  input  logic             trap_en,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf_out,
  output logic             flag_out,
  output logic             range_exc
);
  localparam int SHW  = $clog2(WIDTH);
  localparam int HALF = WIDTH / 2;
  localparam int MSB  = WIDTH - 1;

  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADDC = 5'd1,  OP_SUB = 5'd2;
  localparam logic [4:0] OP_MULS = 5'd3, OP_MULU = 5'd4,  OP_DIVS = 5'd5, OP_DIVU = 5'd6;
  localparam logic [4:0] OP_AND = 5'd7,  OP_OR = 5'd8,    OP_XOR = 5'd9;
  localparam logic [4:0] OP_SLL = 5'd10, OP_SRL = 5'd11,  OP_SRA = 5'd12, OP_ROR = 5'd13;
  localparam logic [4:0] OP_EXBS = 5'd14, OP_EXBZ = 5'd15, OP_EXHS = 5'd16, OP_EXHZ = 5'd17;
  localparam logic [4:0] OP_CMOV = 5'd18, OP_FF1 = 5'd19, OP_FL1 = 5'd20, OP_MOVHI = 5'd21;
  localparam logic [4:0] OP_SFEQ = 5'd22, OP_SFNE = 5'd23;
  localparam logic [4:0] OP_SFGTU = 5'd24, OP_SFGEU = 5'd25, OP_SFLTU = 5'd26, OP_SFLEU = 5'd27;
  localparam logic [4:0] OP_SFGTS = 5'd28, OP_SFGES = 5'd29, OP_SFLTS = 5'd30, OP_SFLES = 5'd31;

  logic [SHW-1:0] shamt;
  assign shamt = op_b[SHW-1:0];

  logic [WIDTH:0] add_sum;
  logic add_ovf;
  assign add_sum = {1'b0, op_a} + {1'b0, op_b}
                 + {{WIDTH{1'b0}}, (opcode == OP_ADDC) & carry_in};
  assign add_ovf = (op_a[MSB] == op_b[MSB]) && (add_sum[MSB] != op_a[MSB]);

  logic [WIDTH-1:0] diff;
  logic sub_ovf;
  assign diff    = op_a - op_b;
  assign sub_ovf = (op_a[MSB] ^ op_b[MSB]) & (op_a[MSB] ^ diff[MSB]);

  logic signed [2*WIDTH-1:0] prod_s;
  logic [2*WIDTH-1:0] prod_u;
  assign prod_s = $signed({{WIDTH{op_a[MSB]}}, op_a}) * $signed({{WIDTH{op_b[MSB]}}, op_b});
  assign prod_u = {{WIDTH{1'b0}}, op_a} * {{WIDTH{1'b0}}, op_b};

  logic div_zero;
  logic [WIDTH-1:0] divisor;
  logic signed [WIDTH:0] quot_s;
  logic [WIDTH-1:0] quot_u;
  assign div_zero = (op_b == '0);
  assign divisor  = div_zero ? WIDTH'(1) : op_b;
  assign quot_s   = $signed({op_a[MSB], op_a}) / $signed({divisor[MSB], divisor});
  assign quot_u   = op_a / divisor;

  logic [2*WIDTH-1:0] rot_wide;
  logic [WIDTH-1:0] sra_val;
  assign rot_wide = {op_a, op_a} >> shamt;
  assign sra_val  = $signed(op_a) >>> shamt;

  logic [WIDTH-1:0] first_one, last_one;
  always_comb begin
    first_one = '0;
    for (int i = WIDTH - 1; i >= 0; i--)
      if (op_a[i]) first_one = WIDTH'(i + 1);
  end
  always_comb begin
    last_one = '0;
    for (int i = 0; i < WIDTH; i++)
      if (op_a[i]) last_one = WIDTH'(i + 1);
  end

  logic eq, ltu, lts;
  assign eq  = (op_a == op_b);
  assign ltu = (op_a < op_b);
  assign lts = ($signed(op_a) < $signed(op_b));

  always_comb begin
    result    = '0;
    carry_out = carry_in;
    ovf_out   = ovf_in;
    flag_out  = flag_in;
    range_exc = 1'b0;
    case (opcode)
      OP_ADD, OP_ADDC: begin
        result    = add_sum[MSB:0];
        carry_out = add_sum[WIDTH];
        ovf_out   = add_ovf;
        range_exc = trap_en & (add_sum[WIDTH] | add_ovf);
      end
      OP_SUB: begin
        result    = diff;
        carry_out = ltu;
        ovf_out   = sub_ovf;
        range_exc = trap_en & (ltu | sub_ovf);
      end
      OP_MULS: begin
        result    = prod_s[MSB:0];
        ovf_out   = (prod_s[2*WIDTH-1:WIDTH] != {WIDTH{prod_s[MSB]}});
        range_exc = trap_en & ovf_out;
      end
      OP_MULU: begin
        result    = prod_u[MSB:0];
        carry_out = (prod_u[2*WIDTH-1:WIDTH] != '0);
        range_exc = trap_en & carry_out;
      end
      OP_DIVS: begin
        result    = quot_s[MSB:0];
        ovf_out   = div_zero;
        range_exc = trap_en & div_zero;
      end
      OP_DIVU: begin
        result    = quot_u;
        carry_out = div_zero;
        range_exc = trap_en & div_zero;
      end
      OP_AND:   result = op_a & op_b;
      OP_OR:    result = op_a | op_b;
      OP_XOR:   result = op_a ^ op_b;
      OP_SLL:   result = op_a << shamt;
      OP_SRL:   result = op_a >> shamt;
      OP_SRA:   result = sra_val;
      OP_ROR:   result = rot_wide[MSB:0];
      OP_EXBS:  result = {{(WIDTH-8){op_a[7]}}, op_a[7:0]};
      OP_EXBZ:  result = {{(WIDTH-8){1'b0}}, op_a[7:0]};
      OP_EXHS:  result = {{(WIDTH-HALF){op_a[HALF-1]}}, op_a[HALF-1:0]};
      OP_EXHZ:  result = {{(WIDTH-HALF){1'b0}}, op_a[HALF-1:0]};
      OP_CMOV:  result = flag_in ? op_a : op_b;
      OP_FF1:   result = first_one;
      OP_FL1:   result = last_one;
      OP_MOVHI: result = {op_b[HALF-1:0], {HALF{1'b0}}};
      OP_SFEQ:  flag_out = eq;
      OP_SFNE:  flag_out = !eq;
      OP_SFGTU: flag_out = !ltu && !eq;
      OP_SFGEU: flag_out = !ltu;
      OP_SFLTU: flag_out = ltu;
      OP_SFLEU: flag_out = ltu || eq;
      OP_SFGTS: flag_out = !lts && !eq;
      OP_SFGES: flag_out = !lts;
      OP_SFLTS: flag_out = lts;
      OP_SFLES: flag_out = lts || eq;
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_alu_chk.sv
module int_exec_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [4:0]       opcode,
  input logic             carry_in,
  input logic             ovf_in,
  input logic             flag_in,
  input logic             trap_en,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             ovf_out,
  input logic             flag_out,
  input logic             range_exc
);
  localparam int HALF = WIDTH / 2;

  always_comb begin
    // R11
    flags_hold_chk: assert (opcode < 5'd7 || (carry_out == carry_in && ovf_out == ovf_in));
    // R10
    cmp_flag_hold_chk: assert (opcode >= 5'd22 || flag_out == flag_in);
    // R10
    cmp_result_zero_chk: assert (opcode < 5'd22 || result == '0);
    // R12
    exc_needs_trap_chk: assert (!range_exc || trap_en);
    // R12
    exc_needs_flag_chk: assert (!range_exc || carry_out || ovf_out);
    // R4
    div_zero_flag_chk: assert (op_b != '0 || !((opcode == 5'd5 && !ovf_out) || (opcode == 5'd6 && !carry_out)));
    // R7
    scan_zero_chk: assert (op_a != '0 || !(opcode == 5'd19 || opcode == 5'd20) || result == '0);
    // R8
    movhi_low_chk: assert (opcode != 5'd21 || result[HALF-1:0] == '0);
  end
endmodule

bind int_exec_alu int_exec_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a(op_a), .op_b(op_b), .opcode(opcode), .carry_in(carry_in),
  .ovf_in(ovf_in), .flag_in(flag_in), .trap_en(trap_en), .result(result),
  .carry_out(carry_out), .ovf_out(ovf_out), .flag_out(flag_out),
  .range_exc(range_exc)
);

// File: tb/int_exec_alu_bench.sv
`timescale 1ns/1ps
module int_exec_alu_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] op_a, op_b, result;
  logic [4:0]  opcode;
  logic carry_in, ovf_in, flag_in, trap_en;
  logic carry_out, ovf_out, flag_out, range_exc;

  int_exec_alu u_int_exec_alu (
    .op_a(op_a), .op_b(op_b), .opcode(opcode), .carry_in(carry_in),
    .ovf_in(ovf_in), .flag_in(flag_in), .trap_en(trap_en), .result(result),
    .carry_out(carry_out), .ovf_out(ovf_out), .flag_out(flag_out),
    .range_exc(range_exc)
  );

  int n_run = 0;
  int n_fail = 0;

  typedef struct packed {
    logic [4:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic ci, oi, fi;
    logic [31:0] r;
    logic co, oo, fo;
  } vec_t;

  typedef struct packed {
    logic [31:0] r;
    logic co, oo, fo, ex;
  } out_t;

  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    '{5'd0,  32'hFFFFFFFF, 32'h1,        1'b0,1'b0,1'b0, 32'h0,        1'b1,1'b0,1'b0}, // R1
    '{5'd0,  32'h7FFFFFFF, 32'h1,        1'b0,1'b0,1'b0, 32'h80000000, 1'b0,1'b1,1'b0}, // R1
    '{5'd1,  32'hFFFFFFFF, 32'h0,        1'b1,1'b0,1'b0, 32'h0,        1'b1,1'b0,1'b0}, // R1
    '{5'd2,  32'h0,        32'h1,        1'b0,1'b0,1'b0, 32'hFFFFFFFF, 1'b1,1'b0,1'b0}, // R2
    '{5'd2,  32'h80000000, 32'h1,        1'b0,1'b0,1'b0, 32'h7FFFFFFF, 1'b0,1'b1,1'b0}, // R2
    '{5'd3,  32'h00010000, 32'h00010000, 1'b1,1'b0,1'b0, 32'h0,        1'b1,1'b1,1'b0}, // R3
    '{5'd4,  32'hFFFFFFFF, 32'h2,        1'b0,1'b0,1'b0, 32'hFFFFFFFE, 1'b1,1'b0,1'b0}, // R3
    '{5'd5,  32'hFFFFFFF9, 32'h2,        1'b0,1'b0,1'b0, 32'hFFFFFFFD, 1'b0,1'b0,1'b0}, // R4
    '{5'd6,  32'h5,        32'h0,        1'b0,1'b0,1'b0, 32'h5,        1'b1,1'b0,1'b0}, // R4
    '{5'd19, 32'h100,      32'h0,        1'b0,1'b0,1'b0, 32'h9,        1'b0,1'b0,1'b0}, // R7
    '{5'd20, 32'h100,      32'h0,        1'b0,1'b0,1'b0, 32'h9,        1'b0,1'b0,1'b0}, // R7
    '{5'd19, 32'h0,        32'h0,        1'b0,1'b0,1'b0, 32'h0,        1'b0,1'b0,1'b0}, // R7
    '{5'd20, 32'h80000001, 32'h0,        1'b0,1'b0,1'b0, 32'h20,       1'b0,1'b0,1'b0}, // R7
    '{5'd13, 32'h1,        32'h1,        1'b0,1'b0,1'b0, 32'h80000000, 1'b0,1'b0,1'b0}, // R5
    '{5'd12, 32'h80000000, 32'd33,       1'b0,1'b0,1'b0, 32'hC0000000, 1'b0,1'b0,1'b0}, // R5
    '{5'd10, 32'h1,        32'h3F,       1'b0,1'b0,1'b0, 32'h80000000, 1'b0,1'b0,1'b0}, // R5
    '{5'd14, 32'h80,       32'h0,        1'b0,1'b0,1'b0, 32'hFFFFFF80, 1'b0,1'b0,1'b0}, // R6
    '{5'd17, 32'hFFFF8000, 32'h0,        1'b0,1'b0,1'b0, 32'h00008000, 1'b0,1'b0,1'b0}, // R6
    '{5'd21, 32'hDEAD0000, 32'h1234ABCD, 1'b0,1'b0,1'b0, 32'hABCD0000, 1'b0,1'b0,1'b0}, // R8
    '{5'd18, 32'h1,        32'h2,        1'b0,1'b0,1'b1, 32'h1,        1'b0,1'b0,1'b1}, // R9
    '{5'd18, 32'h1,        32'h2,        1'b0,1'b0,1'b0, 32'h2,        1'b0,1'b0,1'b0}, // R9
    '{5'd30, 32'hFFFFFFFF, 32'h1,        1'b0,1'b0,1'b0, 32'h0,        1'b0,1'b0,1'b1}, // R10
    '{5'd26, 32'hFFFFFFFF, 32'h1,        1'b0,1'b0,1'b1, 32'h0,        1'b0,1'b0,1'b0}, // R10
    '{5'd7,  32'hF0F0,     32'hFF00,     1'b1,1'b1,1'b0, 32'hF000,     1'b1,1'b1,1'b0}  // R11
  };

  function automatic out_t model(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                                 input logic ci, input logic oi, input logic fi, input logic te);
    out_t o;
    longint sa, sb, ss;
    logic [63:0] ua, ub, us, t;
    logic [4:0] sh;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = {32'h0, a};
    ub = {32'h0, b};
    sh = b[4:0];
    o = '{r: 32'h0, co: ci, oo: oi, fo: fi, ex: 1'b0};
    case (op)
      5'd0, 5'd1: begin
        us = ua + ub + ((op == 5'd1 && ci) ? 64'd1 : 64'd0);
        ss = sa + sb + ((op == 5'd1 && ci) ? 64'sd1 : 64'sd0);
        o.r = us[31:0]; o.co = us[32];
        o.oo = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        o.ex = te & (o.co | o.oo);
      end
      5'd2: begin
        ss = sa - sb; t = ua - ub;
        o.r = t[31:0]; o.co = (ua < ub);
        o.oo = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        o.ex = te & (o.co | o.oo);
      end
      5'd3: begin
        ss = sa * sb; t = ss;
        o.r = t[31:0];
        o.oo = (ss != longint'($signed(t[31:0])));
        o.ex = te & o.oo;
      end
      5'd4: begin
        us = ua * ub;
        o.r = us[31:0]; o.co = (us[63:32] != 0);
        o.ex = te & o.co;
      end
      5'd5: begin
        if (b == 0) begin o.r = a; o.oo = 1'b1; end
        else begin ss = sa / sb; t = ss; o.r = t[31:0]; o.oo = 1'b0; end
        o.ex = te & o.oo;
      end
      5'd6: begin
        if (b == 0) begin o.r = a; o.co = 1'b1; end
        else begin o.r = a / b; o.co = 1'b0; end
        o.ex = te & o.co;
      end
      5'd7:  o.r = a & b;
      5'd8:  o.r = a | b;
      5'd9:  o.r = a ^ b;
      5'd10: o.r = a << sh;
      5'd11: o.r = a >> sh;
      5'd12: begin t = sa >>> sh; o.r = t[31:0]; end
      5'd13: for (int i = 0; i < 32; i++) o.r[i] = a[(i + sh) % 32];
      5'd14: o.r = 32'(sa << 56 >>> 56);
      5'd15: o.r = {24'h0, a[7:0]};
      5'd16: o.r = 32'(sa << 48 >>> 48);
      5'd17: o.r = {16'h0, a[15:0]};
      5'd18: o.r = fi ? a : b;
      5'd19: for (int i = 0; i < 32; i++) if (a[i] && o.r == 0) o.r = 32'(i + 1);
      5'd20: for (int i = 31; i >= 0; i--) if (a[i] && o.r == 0) o.r = 32'(i + 1);
      5'd21: o.r = b << 16;
      5'd22: o.fo = (a == b);
      5'd23: o.fo = (a != b);
      5'd24: o.fo = (ua > ub);
      5'd25: o.fo = (ua >= ub);
      5'd26: o.fo = (ua < ub);
      5'd27: o.fo = (ua <= ub);
      5'd28: o.fo = (sa > sb);
      5'd29: o.fo = (sa >= sb);
      5'd30: o.fo = (sa < sb);
      default: o.fo = (sa <= sb);
    endcase
    return o;
  endfunction

  task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic ci, input logic oi, input logic fi, input logic te);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b;
    carry_in = ci; ovf_in = oi; flag_in = fi; trap_en = te;
    #2;
  endtask

  task automatic check(input string req, input out_t exp);
    out_t act;
    act = '{r: result, co: carry_out, oo: ovf_out, fo: flag_out, ex: range_exc};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h: actual r=%h c=%b v=%b f=%b x=%b expected r=%h c=%b v=%b f=%b x=%b",
               req, opcode, op_a, op_b, act.r, act.co, act.oo, act.fo, act.ex,
               exp.r, exp.co, exp.oo, exp.fo, exp.ex);
    end
  endtask

  function automatic string req_of(input logic [4:0] op);
    if (op <= 5'd1) return "R1";
    if (op == 5'd2) return "R2";
    if (op <= 5'd4) return "R3";
    if (op <= 5'd6) return "R4";
    if (op <= 5'd13) return "R5";
    if (op <= 5'd17) return "R6";
    if (op == 5'd18) return "R9";
    if (op <= 5'd20) return "R7";
    if (op == 5'd21) return "R8";
    return "R10";
  endfunction

  localparam logic [31:0] CORNER [5] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF};

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    opcode = '0; op_a = '0; op_b = '0;
    carry_in = 0; ovf_in = 0; flag_in = 0; trap_en = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #2;
    // reset state: ADD of zeros yields zero and clear flags (R1)
    check("R1", '{r: 32'h0, co: 1'b0, oo: 1'b0, fo: 1'b0, ex: 1'b0});

    for (int i = 0; i < NV; i++) begin
      apply(VT[i].op, VT[i].a, VT[i].b, VT[i].ci, VT[i].oi, VT[i].fi, 1'b0);
      check(req_of(VT[i].op), '{r: VT[i].r, co: VT[i].co, oo: VT[i].oo, fo: VT[i].fo, ex: 1'b0});
    end

    // R12: trap requests
    apply(5'd0, 32'h7FFFFFFF, 32'h1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R12", '{r: 32'h80000000, co: 1'b0, oo: 1'b1, fo: 1'b0, ex: 1'b1});
    apply(5'd0, 32'h1, 32'h1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R12", '{r: 32'h2, co: 1'b0, oo: 1'b0, fo: 1'b0, ex: 1'b0});
    apply(5'd9, 32'h1, 32'h1, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R12", '{r: 32'h0, co: 1'b1, oo: 1'b1, fo: 1'b0, ex: 1'b0});
    apply(5'd6, 32'h9, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R12", '{r: 32'h9, co: 1'b1, oo: 1'b0, fo: 1'b0, ex: 1'b1});
    // R11: compare keeps carry and overflow set
    apply(5'd22, 32'h5, 32'h5, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R11", '{r: 32'h0, co: 1'b1, oo: 1'b1, fo: 1'b1, ex: 1'b0});

    // corner sweep against model over all codes
    for (int op = 0; op < 32; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int f = 0; f < 2; f++) begin
            apply(5'(op), CORNER[i], CORNER[j], f[0], !f[0], f[0], f[0]);
            check(req_of(5'(op)), model(5'(op), CORNER[i], CORNER[j], f[0], !f[0], f[0], f[0]));
          end

    // random sweep
    for (int k = 0; k < 200; k++)
      for (int op = 0; op < 32; op++) begin
        logic [31:0] ra, rb;
        logic [3:0] rf;
        ra = $urandom; rb = $urandom; rf = 4'($urandom);
        if (rf[3]) rb = rb & 32'h0000_00FF;
        apply(5'(op), ra, rb, rf[0], rf[1], rf[2], rf[3]);
        check(req_of(5'(op)), model(5'(op), ra, rb, rf[0], rf[1], rf[2], rf[3]));
      end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule